// File: doc/BRIEF.md
# Data-Space Address Decoder with Program-ROM Window

This block sits between a small controller's data-side load/store path and the storage behind it. Every cycle it classifies the 8-bit data address into one of eight regions and reports that region on a 3-bit code. It raises a write-accept strobe only where a write may land. It also steers one of several read sources onto a single read-data bus. Decode and read steering are combinational, so a load completes in the same cycle as its address.

One slice of the data space, 040h to 07Fh, does not hold data. Reads there pass through to program memory. The block holds a 6-bit page register at data address 0C9h. It places that page above the low six address bits to form a 12-bit program address. Software can therefore page any 64-byte block of program memory into the data space as read-only constants.

The RAM, accumulator, peripherals and the program memory array are outside the block. They return their read data on dedicated inputs. Reads from addresses that decode to nothing return zero, and the following cycle carries a one-cycle error pulse.

Top module: `dspace_decoder`

## Requirements
- R1: While reset is asserted, and once it is released, the page register holds 0 and `acc_err` is low.
- R2: Addresses 000h–03Fh decode to region code 0. They read as FFh, never assert `wr_ok` and never raise `acc_err`.
- R3: Addresses 040h–07Fh decode to region code 1. `rom_addr` equals {page, addr[5:0]} and `rdata` equals `rom_rdata`.
- R4: A write to 040h–07Fh does not assert `wr_ok` and leaves the page register unchanged.
- R5: Addresses 080h–083h decode to region code 2 and 084h–0BFh to region code 3. Both read `ram_rdata`, and a write to either asserts `wr_ok`.
- R6: The peripheral addresses C0h, C1h, C2h, C4h, C5h, C6h, D2h, D3h, D4h and D8h decode to region code 4. They read `periph_rdata` and accept writes.
- R7: Address C9h decodes to region code 5. A write stores wdata[5:0] in the page register. A read returns the page with bits 7:6 zero.
- R8: A page write changes `rom_addr[11:6]` only from the clock edge that ends the write cycle. In the write cycle itself, the old page still drives `rom_addr[11:6]`.
- R9: Address FFh decodes to region code 6, reads `acc_rdata` and accepts writes.
- R10: Every other address in C0h–FEh decodes to region code 7. It reads as 00h and does not assert `wr_ok`.
- R11: A read of a region-7 address makes `acc_err` high for exactly the next cycle. A write, or a read of any other region, leaves `acc_err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 8 | Data-space address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| ram_rdata | input | 8 | Read data from short registers and general RAM |
| periph_rdata | input | 8 | Read data from the selected peripheral register |
| acc_rdata | input | 8 | Accumulator value |
| rom_rdata | input | 8 | Program memory byte at `rom_addr` |
| region | output | 3 | Region code (0 void, 1 window, 2 short, 3 RAM, 4 peripheral, 5 page, 6 accumulator, 7 reserved) |
| wr_ok | output | 1 | Write accepted by a writable region |
| rom_addr | output | 12 | Translated program memory address |
| rdata | output | 8 | Steered read data |
| acc_err | output | 1 | One-cycle pulse after a reserved-address read |

## Verification
The hardest case to reach is the boundary of a page change: the cycle that writes C9h must still show the old page, and the very next window read must use the new one. The bench writes a page value whose upper bits are set, checks the translated address in the write cycle, and then reads the window immediately after. A write into the window follows, and the page is read back to show it was untouched. The error pulse is checked at both of its edges by placing idle cycles after a reserved read, a reserved write and a void read.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  typedef enum logic [2:0] {
    RGN_VOID   = 3'd0,
    RGN_WIN    = 3'd1,
    RGN_SHORT  = 3'd2,
    RGN_RAM    = 3'd3,
    RGN_PERIPH = 3'd4,
    RGN_PAGE   = 3'd5,
    RGN_ACC    = 3'd6,
    RGN_RSVD   = 3'd7
  } region_e;

  localparam int NUM_PERIPH = 10;

  // Implemented peripheral register addresses (entry 0 is the lowest)
  localparam logic [NUM_PERIPH-1:0][7:0] PERIPH_MAP = {
    8'hD8, 8'hD4, 8'hD3, 8'hD2,
    8'hC6, 8'hC5, 8'hC4,
    8'hC2, 8'hC1, 8'hC0
  };

endpackage

// File: rtl/dsd_addr_decode.sv
module dsd_addr_decode
  import dsd_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          OFS_W     = 6,
  parameter int          N_SHORT   = 4,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 8'hC9,
  parameter logic [ADDR_W-1:0] ACC_ADDR  = 8'hFF
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);

  localparam logic [ADDR_W-1:0] WIN_LO    = ADDR_W'(1 << OFS_W);
  localparam logic [ADDR_W-1:0] SHORT_LO  = ADDR_W'(2 << OFS_W);
  localparam logic [ADDR_W-1:0] RAM_LO    = ADDR_W'((2 << OFS_W) + N_SHORT);
  localparam logic [ADDR_W-1:0] PERIPH_LO = ADDR_W'(3 << OFS_W);

  logic [NUM_PERIPH-1:0] periph_hit;

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_periph
    assign periph_hit[g] = (addr == ADDR_W'(PERIPH_MAP[g]));
  end

  always_comb begin
    if (addr < WIN_LO)            region = RGN_VOID;
    else if (addr < SHORT_LO)     region = RGN_WIN;
    else if (addr < RAM_LO)       region = RGN_SHORT;
    else if (addr < PERIPH_LO)    region = RGN_RAM;
    else if (addr == PAGE_ADDR)   region = RGN_PAGE;
    else if (addr == ACC_ADDR)    region = RGN_ACC;
    else if (|periph_hit)         region = RGN_PERIPH;
    else                          region = RGN_RSVD;
  end

endmodule

// File: rtl/dsd_page_reg.sv
module dsd_page_reg #(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] load_val,
  output logic [PAGE_W-1:0] page
);

  logic [PAGE_W-1:0] page_d;

  always_comb begin
    page_d = page;
    if (load) page_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page <= '0;
    else        page <= page_d;
  end

endmodule

// File: rtl/dsd_read_mux.sv
module dsd_read_mux
  import dsd_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter int               PAGE_W   = 6,
  parameter logic [DATA_W-1:0] VOID_VAL = 8'hFF,
  parameter logic [DATA_W-1:0] RSVD_VAL = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  region_e           region,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] periph_rdata,
  input  logic [DATA_W-1:0] acc_rdata,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [PAGE_W-1:0] page,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);

  logic err_d;

  always_comb begin
    unique case (region)
      RGN_VOID:             rdata = VOID_VAL;
      RGN_WIN:              rdata = rom_rdata;
      RGN_SHORT, RGN_RAM:   rdata = ram_rdata;
      RGN_PERIPH:           rdata = periph_rdata;
      RGN_PAGE:             rdata = {{(DATA_W-PAGE_W){1'b0}}, page};
      RGN_ACC:              rdata = acc_rdata;
      default:              rdata = RSVD_VAL;
    endcase
  end

  assign err_d = rd_en && (region == RGN_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err_d;
  end

endmodule

// File: rtl/dspace_decoder.sv
module dspace_decoder
  import dsd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int OFS_W  = 6,
  parameter int PAGE_W = 6,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 8'hC9,
  parameter logic [ADDR_W-1:0] ACC_ADDR  = 8'hFF,
  localparam int ROM_AW = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] periph_rdata,
  input  logic [DATA_W-1:0] acc_rdata,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [2:0]        region,
  output logic              wr_ok,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [DATA_W-1:0] rdata,
  output logic              acc_err
);

  // Reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  region_e           rgn;
  logic [PAGE_W-1:0] page;
  logic              page_load;
  logic              unused_wdata_hi;

  dsd_addr_decode #(
    .ADDR_W    (ADDR_W),
    .OFS_W     (OFS_W),
    .N_SHORT   (4),
    .PAGE_ADDR (PAGE_ADDR),
    .ACC_ADDR  (ACC_ADDR)
  ) u_decode (
    .addr   (addr),
    .region (rgn)
  );

  assign page_load = wr_en && (rgn == RGN_PAGE);

  dsd_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (page_load),
    .load_val (wdata[PAGE_W-1:0]),
    .page     (page)
  );

  assign unused_wdata_hi = ^wdata[DATA_W-1:PAGE_W];

  dsd_read_mux #(
    .DATA_W (DATA_W),
    .PAGE_W (PAGE_W)
  ) u_rmux (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .region       (rgn),
    .rd_en        (rd_en),
    .ram_rdata    (ram_rdata),
    .periph_rdata (periph_rdata),
    .acc_rdata    (acc_rdata),
    .rom_rdata    (rom_rdata),
    .page         (page),
    .rdata        (rdata),
    .err          (acc_err)
  );

  always_comb begin
    unique case (rgn)
      RGN_SHORT, RGN_RAM, RGN_PERIPH, RGN_PAGE, RGN_ACC: wr_ok = wr_en;
      default:                                           wr_ok = 1'b0;
    endcase
  end

  assign region   = rgn;
  assign rom_addr = {page, addr[OFS_W-1:0]};

endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int OFS_W  = 6,
  parameter int PAGE_W = 6,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 8'hC9,
  parameter logic [ADDR_W-1:0] ACC_ADDR  = 8'hFF
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         addr,
  input logic                      rd_en,
  input logic                      wr_en,
  input logic [2:0]                region,
  input logic                      wr_ok,
  input logic [PAGE_W+OFS_W-1:0]   rom_addr,
  input logic [DATA_W-1:0]         rdata,
  input logic                      acc_err
);

  // R3: window reads keep the data offset in the low program bits
  assert_win_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 3'd1) |-> (rom_addr[OFS_W-1:0] == addr[OFS_W-1:0]));

  // R4: nothing in the window accepts a write
  assert_win_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 3'd1) |-> !wr_ok);

  // R8: the page only moves after a cycle that wrote the page register
  assert_page_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && (addr == PAGE_ADDR)) |-> $stable(rom_addr[PAGE_W+OFS_W-1:OFS_W]));

  // R9: the accumulator address always lands in region 6
  assert_acc_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ACC_ADDR) |-> (region == 3'd6));

  // R10: reserved space reads zero and refuses writes
  assert_rsvd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 3'd7) |-> ((rdata == '0) && !wr_ok));

  // R11: an error pulse is always caused by a reserved read one cycle before
  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> ($past(rd_en) && ($past(region) == 3'd7)));

endmodule

bind dspace_decoder dsd_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .OFS_W     (OFS_W),
  .PAGE_W    (PAGE_W),
  .PAGE_ADDR (PAGE_ADDR),
  .ACC_ADDR  (ACC_ADDR)
) u_dsd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .region   (region),
  .wr_ok    (wr_ok),
  .rom_addr (rom_addr),
  .rdata    (rdata),
  .acc_err  (acc_err)
);

// File: tb/dspace_decoder_test.sv
module dspace_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  ram_rdata = 8'h3C;
  logic [7:0]  periph_rdata = 8'hA5;
  logic [7:0]  acc_rdata = 8'h7E;
  logic [7:0]  rom_rdata;
  logic [2:0]  region;
  logic        wr_ok;
  logic [11:0] rom_addr;
  logic [7:0]  rdata;
  logic        acc_err;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rom_fn(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], 4'h9};
  endfunction

  assign rom_rdata = rom_fn(rom_addr);

  dspace_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .ram_rdata(ram_rdata), .periph_rdata(periph_rdata),
    .acc_rdata(acc_rdata), .rom_rdata(rom_rdata), .region(region),
    .wr_ok(wr_ok), .rom_addr(rom_addr), .rdata(rdata), .acc_err(acc_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = r; wr_en = w; wdata = d;
    #1;
  endtask

  task automatic idle();
    drive(8'h84, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_reset();
    drive(8'h40, 1'b1, 1'b0, 8'h00);
    chk("R1 page after reset", 32'(rom_addr[11:6]), 32'h0);
    chk("R1 err after reset", 32'(acc_err), 32'h0);
  endtask

  task automatic t_void();
    drive(8'h00, 1'b1, 1'b0, 8'h00);
    chk("R2 region 00h", 32'(region), 32'd0);
    chk("R2 read 00h", 32'(rdata), 32'hFF);
    drive(8'h3F, 1'b0, 1'b1, 8'h55);
    chk("R2 region 3Fh", 32'(region), 32'd0);
    chk("R2 write 3Fh refused", 32'(wr_ok), 32'h0);
    drive(8'h10, 1'b1, 1'b0, 8'h00);
    idle();
    chk("R2 void read no error", 32'(acc_err), 32'h0);
  endtask

  task automatic t_window();
    drive(8'h40, 1'b1, 1'b0, 8'h00);
    chk("R3 region 40h", 32'(region), 32'd1);
    chk("R3 rom_addr 40h", 32'(rom_addr), 32'h000);
    chk("R3 rdata 40h", 32'(rdata), 32'(rom_fn(12'h000)));
    drive(8'h7F, 1'b1, 1'b0, 8'h00);
    chk("R3 rom_addr 7Fh", 32'(rom_addr), 32'h03F);
    chk("R3 rdata 7Fh", 32'(rdata), 32'(rom_fn(12'h03F)));
  endtask

  task automatic t_short_ram();
    drive(8'h80, 1'b0, 1'b1, 8'h12);
    chk("R5 region 80h", 32'(region), 32'd2);
    chk("R5 write 80h", 32'(wr_ok), 32'h1);
    drive(8'h83, 1'b1, 1'b0, 8'h00);
    chk("R5 region 83h", 32'(region), 32'd2);
    chk("R5 read 83h", 32'(rdata), 32'h3C);
    drive(8'h84, 1'b0, 1'b1, 8'h34);
    chk("R5 region 84h", 32'(region), 32'd3);
    chk("R5 write 84h", 32'(wr_ok), 32'h1);
    drive(8'hBF, 1'b1, 1'b0, 8'h00);
    chk("R5 region BFh", 32'(region), 32'd3);
    chk("R5 read BFh", 32'(rdata), 32'h3C);
  endtask

  task automatic t_periph();
    logic [7:0] plist [10] = '{8'hC0, 8'hC1, 8'hC2, 8'hC4, 8'hC5,
                               8'hC6, 8'hD2, 8'hD3, 8'hD4, 8'hD8};
    for (int i = 0; i < 10; i++) begin
      drive(plist[i], 1'b1, 1'b0, 8'h00);
      chk("R6 peripheral region", 32'(region), 32'd4);
      chk("R6 peripheral read", 32'(rdata), 32'hA5);
    end
    drive(8'hD8, 1'b0, 1'b1, 8'h01);
    chk("R6 peripheral write", 32'(wr_ok), 32'h1);
  endtask

  task automatic t_page();
    drive(8'hC9, 1'b0, 1'b1, 8'hEA);
    chk("R7 region C9h", 32'(region), 32'd5);
    chk("R7 page write accepted", 32'(wr_ok), 32'h1);
    chk("R8 old page in write cycle", 32'(rom_addr[11:6]), 32'h00);
    drive(8'h45, 1'b1, 1'b0, 8'h00);
    chk("R8 new page next cycle", 32'(rom_addr), 32'hA85);
    chk("R3 paged rdata", 32'(rdata), 32'(rom_fn(12'hA85)));
    drive(8'hC9, 1'b1, 1'b0, 8'h00);
    chk("R7 page readback", 32'(rdata), 32'h2A);
  endtask

  task automatic t_window_write();
    drive(8'h50, 1'b0, 1'b1, 8'h11);
    chk("R4 window region", 32'(region), 32'd1);
    chk("R4 window write refused", 32'(wr_ok), 32'h0);
    drive(8'hC9, 1'b1, 1'b0, 8'h00);
    chk("R4 page untouched", 32'(rdata), 32'h2A);
  endtask

  task automatic t_acc();
    drive(8'hFF, 1'b1, 1'b0, 8'h00);
    chk("R9 region FFh", 32'(region), 32'd6);
    chk("R9 read FFh", 32'(rdata), 32'h7E);
    drive(8'hFF, 1'b0, 1'b1, 8'h99);
    chk("R9 write FFh", 32'(wr_ok), 32'h1);
  endtask

  task automatic t_reserved();
    logic [7:0] rlist [4] = '{8'hC3, 8'hC8, 8'hD5, 8'hFE};
    for (int i = 0; i < 4; i++) begin
      drive(rlist[i], 1'b0, 1'b1, 8'h77);
      chk("R10 reserved region", 32'(region), 32'd7);
      chk("R10 reserved write refused", 32'(wr_ok), 32'h0);
      chk("R10 reserved read value", 32'(rdata), 32'h00);
    end
    idle();
    chk("R11 no error after reserved write", 32'(acc_err), 32'h0);
  endtask

  task automatic t_err_pulse();
    drive(8'hC3, 1'b1, 1'b0, 8'h00);
    chk("R11 no error in read cycle", 32'(acc_err), 32'h0);
    idle();
    chk("R11 error next cycle", 32'(acc_err), 32'h1);
    idle();
    chk("R11 error one cycle long", 32'(acc_err), 32'h0);
    drive(8'hFF, 1'b1, 1'b0, 8'h00);
    idle();
    chk("R11 no error after valid read", 32'(acc_err), 32'h0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 err in reset", 32'(acc_err), 32'h0);
    chk("R1 page in reset", 32'(rom_addr[11:6]), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_void();
    t_window();
    t_short_ram();
    t_periph();
    t_page();
    t_window_write();
    t_acc();
    t_reserved();
    t_err_pulse();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule